// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block watches the command strobes of a four-bank SDRAM and follows each bank's state from one cycle to the next. It decodes every command from the active-low row strobe, column strobe and write enable, together with the bank-select bits and address bit 10. For each bank it keeps an idle/open flag and the row that was opened. It runs down-counters for the activate-to-column delay, the activate-to-activate period of that bank, and the minimum and maximum open time. A single shared counter enforces the spacing between activates to different banks.

A controller can use the per-bank `act_ok`, `rw_ok` and `pre_ok` outputs to decide which command may go out in the next cycle. A protocol monitor can instead read the sticky violation outputs, each of which latches the first breach of one timing or ordering rule. All delays are module parameters counted in clock cycles. A "gap of k" below means that the second command is sampled k rising edges after the first.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Commands are decoded as {ras_n, cas_n, we_n}: 011 activate, 010 precharge (addr[10]=0 acts on bank `ba`, addr[10]=1 acts on all banks), 101 read, 100 write. The codes 111, 001, 000 and 110 change no state and set no flag.
- R2: An activate opens bank `ba` and stores addr[ROW_W-1:0]. From the following cycle `bank_open[ba]` is 1 and slice `ba` of `open_row` shows that row.
- R3: `rw_ok[b]` is 1 only while bank b is open and at least T_RCD cycles have passed since its activate. A read or write at a gap below T_RCD sets `viol_rcd`.
- R4: An activate to an idle bank at a gap below T_RC from that bank's previous activate sets `viol_rc`. `act_ok[b]` is 0 while bank b is open or inside that window.
- R5: An activate to a bank other than the most recently activated one, at a gap below T_RRD, sets `viol_rrd`. During that window `act_ok` is 0 for every other bank.
- R6: `pre_ok[b]` is 1 only while bank b is open and at least T_RAS_MIN cycles have passed since its activate. A single or all-bank precharge that closes an open bank at a gap below T_RAS_MIN sets `viol_ras_min`.
- R7: A bank that is still open T_RAS_MAX cycles after its activate, with no precharge sampled at that edge, sets `viol_ras_max`. A precharge at a gap of exactly T_RAS_MAX sets nothing.
- R8: A precharge with addr[10]=1 closes every bank whatever `ba` holds. It sets no flag for banks that are already idle.
- R9: A read, a write or a single-bank precharge to an idle bank sets `viol_idle_cmd` and changes no bank state.
- R10: After reset all banks are idle, all open rows are 0, every flag is 0 and every `act_ok` bit is 1. Each flag stays set until the next reset.
- R11: An activate to an already open bank sets `viol_reopen`. A command that breaks a timing rule is still applied: the bank opens or closes and the row is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ROW_W | Address bus; bit 10 selects all-bank precharge |
| bank_open | output | NUM_BANKS | Per-bank open flag |
| open_row | output | NUM_BANKS*ROW_W | Open row of each bank, bank b at bits b*ROW_W upward |
| act_ok | output | NUM_BANKS | Activate allowed next cycle |
| rw_ok | output | NUM_BANKS | Read or write allowed next cycle |
| pre_ok | output | NUM_BANKS | Precharge allowed next cycle |
| viol_rcd | output | 1 | Sticky: column command too early |
| viol_rc | output | 1 | Sticky: same-bank activate too early |
| viol_rrd | output | 1 | Sticky: cross-bank activate too early |
| viol_ras_min | output | 1 | Sticky: precharge too early |
| viol_ras_max | output | 1 | Sticky: bank open too long |
| viol_idle_cmd | output | 1 | Sticky: column or precharge command to an idle bank |
| viol_reopen | output | 1 | Sticky: activate to an open bank |

## Verification
The in-RTL assertions check on every cycle that an activate opens the bank with the sampled row and masks `rw_ok` and `pre_ok` in the next cycle, and that any precharge leaves the bank idle. They also check that a command to an idle bank leaves it idle, that the cross-bank window starts after each activate, and that no flag ever drops once set. The exact cycle at which each timing window ends can only be shown by the bench's gap sweeps. The same holds for the split between flagged and clean commands at each boundary and for all-bank precharge ignoring the bank bits.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    C_NOP,
    C_ACT,
    C_PRE_ONE,
    C_PRE_ALL,
    C_RD,
    C_WR,
    C_OTHER
  } trk_cmd_e;

  function automatic trk_cmd_e trk_decode(input logic ras_n, input logic cas_n,
                                          input logic we_n, input logic ap);
    trk_cmd_e c;
    unique case ({ras_n, cas_n, we_n})
      3'b011:  c = C_ACT;
      3'b010:  c = ap ? C_PRE_ALL : C_PRE_ONE;
      3'b101:  c = C_RD;
      3'b100:  c = C_WR;
      3'b111:  c = C_NOP;
      default: c = C_OTHER;
    endcase
    return c;
  endfunction

  function automatic int trk_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // flag vector bit positions
  localparam int F_RCD    = 0;
  localparam int F_RC     = 1;
  localparam int F_RRD    = 2;
  localparam int F_RASMIN = 3;
  localparam int F_RASMAX = 4;
  localparam int F_IDLE   = 5;
  localparam int F_REOPEN = 6;
  localparam int F_NUM    = 7;

endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
  import sdram_trk_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            ap,
  input  logic [BA_W-1:0] ba,
  output logic [NB-1:0]   act_hit,
  output logic [NB-1:0]   rw_hit,
  output logic [NB-1:0]   pre1_hit,
  output logic            pre_all,
  output logic            act_any
);

  trk_cmd_e cmd;

  assign cmd     = trk_decode(ras_n, cas_n, we_n, ap);
  assign pre_all = (cmd == C_PRE_ALL);
  assign act_any = (cmd == C_ACT);

  for (genvar b = 0; b < NB; b++) begin : g_sel
    logic sel;
    assign sel         = (ba == BA_W'(b));
    assign act_hit[b]  = sel && (cmd == C_ACT);
    assign rw_hit[b]   = sel && ((cmd == C_RD) || (cmd == C_WR));
    assign pre1_hit[b] = sel && (cmd == C_PRE_ONE);
  end

endmodule

// File: rtl/sdram_trk_rrd.sv
module sdram_trk_rrd #(
  parameter int NB    = 4,
  parameter int BA_W  = 2,
  parameter int T_RRD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_any,
  input  logic [BA_W-1:0] ba,
  output logic [NB-1:0]   block_o,
  output logic            v_rrd
);

  localparam int CW = $clog2(T_RRD + 1);

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BA_W-1:0] last_q, last_d;
  logic            busy;

  assign busy  = (cnt_q != '0);
  assign v_rrd = act_any && busy && (ba != last_q);

  for (genvar b = 0; b < NB; b++) begin : g_blk
    assign block_o[b] = busy && (last_q != BA_W'(b));
  end

  always_comb begin
    cnt_d  = busy ? cnt_q - 1'b1 : cnt_q;
    last_d = last_q;
    if (act_any) begin
      cnt_d  = CW'(T_RRD - 1);
      last_d = ba;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  if (T_RRD > 1 && NB > 1) begin : g_chk
    // R5: every activate opens a window that blocks the other banks
    assert_rrd_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act_any |=> (block_o != '0));
  end

endmodule

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank
  import sdram_trk_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 9,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_hit,
  input  logic             rw_hit,
  input  logic             pre1_hit,
  input  logic             pre_all,
  input  logic [ROW_W-1:0] row_in,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_free_o,
  output logic             rw_ok_o,
  output logic             pre_ok_o,
  output logic [F_NUM-1:0] viol_o
);

  localparam int TOP = trk_max(trk_max(T_RCD, T_RC), trk_max(T_RAS_MIN, T_RAS_MAX));
  localparam int CW  = $clog2(TOP + 1);

  logic             active_q, active_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [CW-1:0]    rcd_q, rcd_d, rc_q, rc_d, rasn_q, rasn_d, rasx_q, rasx_d;
  logic             pre_any;

  assign pre_any    = pre1_hit || pre_all;
  assign active_o   = active_q;
  assign row_o      = row_q;
  assign act_free_o = !active_q && (rc_q == '0);
  assign rw_ok_o    = active_q && (rcd_q == '0);
  assign pre_ok_o   = active_q && (rasn_q == '0);

  always_comb begin
    viol_o           = '0;
    viol_o[F_RCD]    = rw_hit && active_q && (rcd_q != '0);
    viol_o[F_RC]     = act_hit && !active_q && (rc_q != '0);
    viol_o[F_REOPEN] = act_hit && active_q;
    viol_o[F_RASMIN] = pre_any && active_q && (rasn_q != '0);
    viol_o[F_RASMAX] = active_q && (rasx_q == '0) && !pre_any;
    viol_o[F_IDLE]   = (rw_hit || pre1_hit) && !active_q;
  end

  always_comb begin
    active_d = active_q;
    row_d    = row_q;
    rcd_d    = (rcd_q  != '0) ? rcd_q  - 1'b1 : rcd_q;
    rc_d     = (rc_q   != '0) ? rc_q   - 1'b1 : rc_q;
    rasn_d   = (rasn_q != '0) ? rasn_q - 1'b1 : rasn_q;
    rasx_d   = (rasx_q != '0) ? rasx_q - 1'b1 : rasx_q;
    if (act_hit) begin
      active_d = 1'b1;
      row_d    = row_in;
      rcd_d    = CW'(T_RCD - 1);
      rc_d     = CW'(T_RC - 1);
      rasn_d   = CW'(T_RAS_MIN - 1);
      rasx_d   = CW'(T_RAS_MAX - 1);
    end else if (pre_any) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      row_q    <= '0;
      rcd_q    <= '0;
      rc_q     <= '0;
      rasn_q   <= '0;
      rasx_q   <= '0;
    end else begin
      active_q <= active_d;
      row_q    <= row_d;
      rcd_q    <= rcd_d;
      rc_q     <= rc_d;
      rasn_q   <= rasn_d;
      rasx_q   <= rasx_d;
    end
  end

  // R2: activate opens the bank with the sampled row
  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |=> (active_o && row_o == $past(row_in)));

  // R8: any precharge leaves the bank idle
  assert_pre_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_any && !act_hit) |=> !active_o);

  // R9: a column or single precharge to an idle bank keeps it idle
  assert_idle_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rw_hit || pre1_hit) && !active_o) |=> !active_o);

  if (T_RCD > 1) begin : g_rcd_chk
    // R3: no column command allowed right after activate
    assert_rcd_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act_hit |=> !rw_ok_o);
  end

  if (T_RAS_MIN > 1) begin : g_ras_chk
    // R6: no precharge allowed right after activate
    assert_rasmin_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_hit |=> !pre_ok_o);
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 40,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_row,
  output logic [NUM_BANKS-1:0]       act_ok,
  output logic [NUM_BANKS-1:0]       rw_ok,
  output logic [NUM_BANKS-1:0]       pre_ok,
  output logic                       viol_rcd,
  output logic                       viol_rc,
  output logic                       viol_rrd,
  output logic                       viol_ras_min,
  output logic                       viol_ras_max,
  output logic                       viol_idle_cmd,
  output logic                       viol_reopen
);

  logic [1:0]           rst_pipe_q;
  logic                 rst_sync_n;
  logic [NUM_BANKS-1:0] act_hit, rw_hit, pre1_hit, act_free, rrd_block;
  logic                 pre_all, act_any, v_rrd;
  logic [F_NUM-1:0]     bank_viol [NUM_BANKS];
  logic [F_NUM-1:0]     viol_now, viol_q, viol_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sdram_trk_decode #(.NB(NUM_BANKS), .BA_W(BA_W)) u_dec (
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ap(addr[AP_BIT]), .ba(ba),
    .act_hit(act_hit), .rw_hit(rw_hit), .pre1_hit(pre1_hit),
    .pre_all(pre_all), .act_any(act_any)
  );

  sdram_trk_rrd #(.NB(NUM_BANKS), .BA_W(BA_W), .T_RRD(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_sync_n), .act_any(act_any), .ba(ba),
    .block_o(rrd_block), .v_rrd(v_rrd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_trk_bank #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC),
      .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX)
    ) u_bank (
      .clk(clk), .rst_n(rst_sync_n),
      .act_hit(act_hit[b]), .rw_hit(rw_hit[b]), .pre1_hit(pre1_hit[b]),
      .pre_all(pre_all), .row_in(addr),
      .active_o(bank_open[b]), .row_o(open_row[b*ROW_W +: ROW_W]),
      .act_free_o(act_free[b]), .rw_ok_o(rw_ok[b]), .pre_ok_o(pre_ok[b]),
      .viol_o(bank_viol[b])
    );
  end

  assign act_ok = act_free & ~rrd_block;

  always_comb begin
    viol_now = '0;
    for (int b = 0; b < NUM_BANKS; b++) viol_now = viol_now | bank_viol[b];
    viol_now[F_RRD] = v_rrd;
    viol_d = viol_q | viol_now;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) viol_q <= '0;
    else             viol_q <= viol_d;
  end

  assign viol_rcd      = viol_q[F_RCD];
  assign viol_rc       = viol_q[F_RC];
  assign viol_rrd      = viol_q[F_RRD];
  assign viol_ras_min  = viol_q[F_RASMIN];
  assign viol_ras_max  = viol_q[F_RASMAX];
  assign viol_idle_cmd = viol_q[F_IDLE];
  assign viol_reopen   = viol_q[F_REOPEN];

  // R10: a set flag never drops before reset
  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (viol_q != '0) |=> ((viol_q & $past(viol_q)) == $past(viol_q)));

endmodule

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb_top;

  localparam int NB    = 4;
  localparam int RW    = 12;
  localparam int TRCD  = 3;
  localparam int TRC   = 7;
  localparam int TRRD  = 2;
  localparam int TRASN = 4;
  localparam int TRASX = 12;

  localparam logic [2:0] K_ACT = 3'b011;
  localparam logic [2:0] K_PRE = 3'b010;
  localparam logic [2:0] K_RD  = 3'b101;
  localparam logic [2:0] K_WR  = 3'b100;
  localparam logic [2:0] K_NOP = 3'b111;

  // flag vector {reopen, idle, rasmax, rasmin, rrd, rc, rcd}
  localparam logic [6:0] FL_RCD    = 7'b0000001;
  localparam logic [6:0] FL_RC     = 7'b0000010;
  localparam logic [6:0] FL_RRD    = 7'b0000100;
  localparam logic [6:0] FL_RASMIN = 7'b0001000;
  localparam logic [6:0] FL_RASMAX = 7'b0010000;
  localparam logic [6:0] FL_IDLE   = 7'b0100000;
  localparam logic [6:0] FL_REOPEN = 7'b1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [RW-1:0] addr = '0;
  logic [NB-1:0] bank_open, act_ok, rw_ok, pre_ok;
  logic [NB*RW-1:0] open_row;
  logic viol_rcd, viol_rc, viol_rrd, viol_ras_min, viol_ras_max, viol_idle_cmd, viol_reopen;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_bank_tracker #(
    .NUM_BANKS(NB), .ROW_W(RW), .AP_BIT(10), .T_RCD(TRCD), .T_RC(TRC),
    .T_RRD(TRRD), .T_RAS_MIN(TRASN), .T_RAS_MAX(TRASX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .bank_open(bank_open), .open_row(open_row),
    .act_ok(act_ok), .rw_ok(rw_ok), .pre_ok(pre_ok),
    .viol_rcd(viol_rcd), .viol_rc(viol_rc), .viol_rrd(viol_rrd),
    .viol_ras_min(viol_ras_min), .viol_ras_max(viol_ras_max),
    .viol_idle_cmd(viol_idle_cmd), .viol_reopen(viol_reopen)
  );

  function automatic logic [6:0] flags();
    return {viol_reopen, viol_idle_cmd, viol_ras_max, viol_ras_min, viol_rrd, viol_rc, viol_rcd};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input int bank, input logic [RW-1:0] a);
    {ras_n, cas_n, we_n} = code;
    ba   = 2'(bank);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    {ras_n, cas_n, we_n} = K_NOP;
    ba   = '0;
    addr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    {ras_n, cas_n, we_n} = K_NOP;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R10: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    do_reset();

    // R10 reset state
    chk("R10", "bank_open", 64'(bank_open), 64'h0);
    chk("R10", "open_row", 64'(open_row), 64'h0);
    chk("R10", "flags", 64'(flags()), 64'h0);
    chk("R10", "act_ok", 64'(act_ok), 64'hF);
    chk("R10", "rw_ok", 64'(rw_ok), 64'h0);
    chk("R10", "pre_ok", 64'(pre_ok), 64'h0);

    // R2 open each bank with its own row
    for (int b = 0; b < NB; b++) begin
      do_reset();
      issue(K_ACT, b, RW'(12'h123 + b * 12'h2B1));
      chk("R2", "bank_open", 64'(bank_open), 64'(1 << b));
      for (int k = 0; k < NB; k++)
        chk("R2", "open_row", 64'(open_row[k*RW +: RW]),
            (k == b) ? 64'(RW'(12'h123 + b * 12'h2B1)) : 64'h0);
    end

    // R3 activate-to-column sweep, read and write
    for (int b = 0; b < NB; b++) begin
      for (int g = 1; g <= TRCD + 1; g++) begin
        for (int w = 0; w < 2; w++) begin
          do_reset();
          issue(K_ACT, b, 12'h055);
          idle(g - 1);
          chk("R3", "rw_ok", 64'(rw_ok[b]), 64'(g >= TRCD));
          issue(w ? K_WR : K_RD, b, 12'h007);
          chk("R3", "flags", 64'(flags()), (g < TRCD) ? 64'(FL_RCD) : 64'h0);
          chk("R3", "bank_open", 64'(bank_open), 64'(1 << b));
        end
      end
    end

    // R4 same-bank activate period sweep
    for (int g = TRASN + 1; g <= TRC + 1; g++) begin
      do_reset();
      issue(K_ACT, 1, 12'h100);
      chk("R4", "act_ok open", 64'(act_ok[1]), 64'h0);
      idle(TRASN - 1);
      issue(K_PRE, 1, 12'h000);
      idle(g - TRASN - 1);
      chk("R4", "act_ok", 64'(act_ok[1]), 64'(g >= TRC));
      issue(K_ACT, 1, 12'h200);
      chk("R4", "flags", 64'(flags()), (g < TRC) ? 64'(FL_RC) : 64'h0);
      chk("R11", "row", 64'(open_row[RW +: RW]), 64'h200);
    end

    // R11 activate to an open bank: flagged and row replaced
    do_reset();
    issue(K_ACT, 2, 12'h0A0);
    idle(TRC);
    issue(K_ACT, 2, 12'h0B0);
    chk("R11", "flags", 64'(flags()), 64'(FL_REOPEN));
    chk("R11", "row", 64'(open_row[2*RW +: RW]), 64'h0B0);
    chk("R11", "rw_ok", 64'(rw_ok[2]), 64'h0);

    // R5 cross-bank spacing sweep over all ordered pairs
    for (int a = 0; a < NB; a++) begin
      for (int b = 0; b < NB; b++) begin
        if (a != b) begin
          for (int g = 1; g <= TRRD + 1; g++) begin
            do_reset();
            issue(K_ACT, a, 12'h011);
            idle(g - 1);
            chk("R5", "act_ok", 64'(act_ok[b]), 64'(g >= TRRD));
            issue(K_ACT, b, 12'h022);
            chk("R5", "flags", 64'(flags()), (g < TRRD) ? 64'(FL_RRD) : 64'h0);
            chk("R5", "bank_open", 64'(bank_open), 64'((1 << a) | (1 << b)));
          end
        end
      end
    end

    // R6 minimum open time sweep, single and all-bank precharge
    for (int g = 1; g <= TRASN + 1; g++) begin
      for (int all = 0; all < 2; all++) begin
        do_reset();
        issue(K_ACT, 2, 12'h333);
        idle(g - 1);
        chk("R6", "pre_ok", 64'(pre_ok[2]), 64'(g >= TRASN));
        issue(K_PRE, all ? 0 : 2, all ? 12'h400 : 12'h000);
        chk("R6", "flags", 64'(flags()), (g < TRASN) ? 64'(FL_RASMIN) : 64'h0);
        chk("R11", "bank_open", 64'(bank_open), 64'h0);
      end
    end

    // R7 maximum open time boundary
    do_reset();
    issue(K_ACT, 3, 12'h0F0);
    idle(TRASX - 1);
    chk("R7", "flags before limit", 64'(flags()), 64'h0);
    issue(K_PRE, 3, 12'h000);
    chk("R7", "flags pre at limit", 64'(flags()), 64'h0);
    do_reset();
    issue(K_ACT, 3, 12'h0F0);
    idle(TRASX - 1);
    chk("R7", "flags at limit-1", 64'(flags()), 64'h0);
    idle(1);
    chk("R7", "flags past limit", 64'(flags()), 64'(FL_RASMAX));
    idle(5);
    chk("R10", "flag sticky", 64'(flags()), 64'(FL_RASMAX));

    // R8 all-bank precharge with arbitrary bank bits
    for (int sel = 0; sel < NB; sel++) begin
      do_reset();
      issue(K_ACT, 0, 12'h001);
      idle(TRRD - 1);
      issue(K_ACT, 1, 12'h002);
      idle(TRRD - 1);
      issue(K_ACT, 2, 12'h003);
      idle(TRASN);
      issue(K_PRE, sel, 12'h400);
      chk("R8", "bank_open", 64'(bank_open), 64'h0);
      chk("R8", "flags", 64'(flags()), 64'h0);
    end
    do_reset();
    issue(K_PRE, 3, 12'h7FF);
    chk("R8", "flags all idle", 64'(flags()), 64'h0);

    // R1 single precharge closes only the addressed bank
    do_reset();
    issue(K_ACT, 0, 12'h010);
    idle(TRRD - 1);
    issue(K_ACT, 1, 12'h020);
    idle(TRASN);
    issue(K_PRE, 1, 12'hBFF);
    chk("R1", "bank_open", 64'(bank_open), 64'h1);
    chk("R1", "flags", 64'(flags()), 64'h0);

    // R1 non-decoded codes do nothing to an open bank
    do_reset();
    issue(K_ACT, 0, 12'h3C3);
    idle(TRCD);
    issue(3'b001, 0, 12'h400);
    issue(3'b000, 0, 12'h000);
    issue(3'b110, 0, 12'h400);
    issue(K_NOP, 0, 12'hFFF);
    chk("R1", "bank_open", 64'(bank_open), 64'h1);
    chk("R1", "row", 64'(open_row[0 +: RW]), 64'h3C3);
    chk("R1", "flags", 64'(flags()), 64'h0);

    // R9 commands to idle banks
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < 3; k++) begin
        do_reset();
        issue((k == 0) ? K_RD : (k == 1) ? K_WR : K_PRE, b, 12'h000);
        chk("R9", "flags", 64'(flags()), 64'(FL_IDLE));
        chk("R9", "bank_open", 64'(bank_open), 64'h0);
        chk("R9", "act_ok", 64'(act_ok), 64'hF);
      end
    end

    // R10 reset clears sticky flags
    do_reset();
    chk("R10", "flags after reset", 64'(flags()), 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule